// File: doc/BRIEF.md
# Windowed Watchdog Timer with Configuration Lock

This block watches over running software. A 16-bit counter counts down by one on each pulse of a slow timer tick, not on every system clock cycle. Software keeps the system alive by writing to a service address, which reloads the counter from a programmable load register. If the counter is already at zero when the next tick arrives, the block raises a one-cycle reset request and can also set a sticky interrupt flag. The counter then reloads and stops until software starts it again.

In windowed mode the load value is the upper limit and a separate threshold register is the lower edge of the window. A service made while the running counter is still above the threshold is too early. It is treated exactly like a timeout. A key-protected lock freezes the load, threshold and control registers against stray writes. Access uses a simple single-cycle write strobe with an address, and a combinational read port.

Top module: `wdw_win_top`

## Requirements
- R1: After reset the load and threshold registers read 16'hFFFF, the count reads 16'hFFFF, control reads 0, the lock reads 0, and both `rst_req` and `irq` are low.
- R2: The count decreases by exactly one on each cycle with `tick` high while control bit 0 (run) is set. It holds its value on cycles without a tick and whenever run is clear.
- R3: When `tick` arrives while running with the count at zero, a timeout occurs. The counter reloads from the load register and run clears. If control bit 3 (reset enable) is set, `rst_req` is high for exactly one cycle, in the cycle after that edge.
- R4: Any write to address 1 services the watchdog and reloads the count from the load register, whatever the data. Reading address 1 returns the current count. Writing address 0 does not reload the count.
- R5: With control bit 1 (windowed) set and run set, a service while the count is greater than the threshold at address 4 is a violation with the same effect as a timeout.
- R6: In windowed mode, a service while the count is at or below the threshold only reloads the counter and raises no request.
- R7: A service while run is clear only reloads the counter and never causes a violation.
- R8: Writing any value other than 16'h1ACC to address 3 engages the lock, and writing 16'h1ACC releases it. Address 3 reads 1 while locked. While locked, writes to addresses 0, 2 and 4 are ignored.
- R9: If control bit 2 (interrupt enable) is set, a timeout or violation sets the flag that drives `irq`. The flag reads at address 5 bit 0 and stays set until a write with bit 0 set to address 5. A write of 0 there has no effect.
- R10: A timeout or violation arriving in the same cycle as a control write leaves run cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Timer-clock enable, one cycle per count step |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address for reads and writes |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr` (combinational) |
| rst_req | output | 1 | One-cycle system reset request |
| irq | output | 1 | Sticky timeout interrupt flag |

## Verification
The bench builds the block with its default 16-bit counter and lock key. It drives `tick` directly rather than deriving it from a slow oscillator. Because the load value is programmable, small loads of 3 and 10 bring the zero-count expiry, the early-service boundary (count equal to and above the threshold) and the interrupt path within a few dozen cycles. The lock and reload rules are still checked against full-width reset values.

// File: rtl/wdw_pkg.sv
package wdw_pkg;

    typedef enum logic [2:0] {
        A_LOAD  = 3'd0,
        A_COUNT = 3'd1,
        A_CTRL  = 3'd2,
        A_LOCK  = 3'd3,
        A_WIN   = 3'd4,
        A_FLAG  = 3'd5
    } wdw_addr_e;

    typedef struct packed {
        logic rst_en;
        logic irq_en;
        logic windowed;
        logic run;
    } wdw_ctrl_t;

    localparam int CTRL_W = $bits(wdw_ctrl_t);

    function automatic wdw_ctrl_t to_ctrl(input logic [CTRL_W-1:0] v);
        return wdw_ctrl_t'(v);
    endfunction

    function automatic logic hit(input logic en, input logic [2:0] a, input wdw_addr_e want);
        return en && (a == want);
    endfunction

endpackage

// File: rtl/wdw_count.sv
module wdw_count
    import wdw_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  wdw_ctrl_t        ctrl,
    input  logic             svc,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] win_val,
    output logic [CNT_W-1:0] count_q,
    output logic             evt
);
    logic early;
    logic expire;

    always_comb begin
        early  = svc && ctrl.run && ctrl.windowed && (count_q > win_val);
        expire = tick && ctrl.run && !svc && (count_q == '0);
        evt    = early || expire;
    end

    always_ff @(posedge clk) begin
        if (rst)
            count_q <= '1;
        else if (svc || evt)
            count_q <= load_val;
        else if (ctrl.run && tick)
            count_q <= count_q - 1'b1;
    end
endmodule

// File: rtl/wdw_regs.sv
module wdw_regs
    import wdw_pkg::*;
#(
    parameter int               CNT_W    = 16,
    parameter logic [CNT_W-1:0] LOCK_KEY = 16'h1ACC
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [2:0]       addr,
    input  logic [CNT_W-1:0] wdata,
    input  logic             evt,
    output logic [CNT_W-1:0] load_q,
    output logic [CNT_W-1:0] win_q,
    output wdw_ctrl_t        ctrl_q,
    output logic             locked_q,
    output logic             flag_q,
    output logic             rst_req_q
);
    logic cfg_ok;
    assign cfg_ok = wr_en && !locked_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            load_q    <= '1;
            win_q     <= '1;
            ctrl_q    <= '0;
            locked_q  <= 1'b0;
            flag_q    <= 1'b0;
            rst_req_q <= 1'b0;
        end else begin
            rst_req_q <= evt && ctrl_q.rst_en;
            if (hit(cfg_ok, addr, A_LOAD)) load_q <= wdata;
            if (hit(cfg_ok, addr, A_WIN))  win_q  <= wdata;
            if (hit(cfg_ok, addr, A_CTRL)) ctrl_q <= to_ctrl(wdata[CTRL_W-1:0]);
            if (hit(wr_en, addr, A_LOCK))  locked_q <= (wdata != LOCK_KEY);
            if (hit(wr_en, addr, A_FLAG) && wdata[0]) flag_q <= 1'b0;
            if (evt) begin
                ctrl_q.run <= 1'b0;
                if (ctrl_q.irq_en) flag_q <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/wdw_rdmux.sv
module wdw_rdmux
    import wdw_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic [2:0]       addr,
    input  logic [CNT_W-1:0] load_q,
    input  logic [CNT_W-1:0] count_q,
    input  logic [CNT_W-1:0] win_q,
    input  wdw_ctrl_t        ctrl_q,
    input  logic             locked_q,
    input  logic             flag_q,
    output logic [CNT_W-1:0] rdata
);
    always_comb begin
        rdata = '0;
        case (addr)
            A_LOAD:  rdata = load_q;
            A_COUNT: rdata = count_q;
            A_CTRL:  rdata[CTRL_W-1:0] = ctrl_q;
            A_LOCK:  rdata[0] = locked_q;
            A_WIN:   rdata = win_q;
            A_FLAG:  rdata[0] = flag_q;
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/wdw_win_top.sv
module wdw_win_top
    import wdw_pkg::*;
#(
    parameter int               CNT_W    = 16,
    parameter logic [CNT_W-1:0] LOCK_KEY = 16'h1ACC
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             wr_en,
    input  logic [2:0]       addr,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] rdata,
    output logic             rst_req,
    output logic             irq
);
    logic [CNT_W-1:0] load_q, win_q, count_q;
    wdw_ctrl_t        ctrl_q;
    logic             locked_q, flag_q, evt, svc;

    assign svc = hit(wr_en, addr, A_COUNT);

    wdw_regs #(.CNT_W(CNT_W), .LOCK_KEY(LOCK_KEY)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .evt(evt), .load_q(load_q), .win_q(win_q), .ctrl_q(ctrl_q),
        .locked_q(locked_q), .flag_q(flag_q), .rst_req_q(rst_req)
    );

    wdw_count #(.CNT_W(CNT_W)) u_count (
        .clk(clk), .rst(rst), .tick(tick), .ctrl(ctrl_q), .svc(svc),
        .load_val(load_q), .win_val(win_q), .count_q(count_q), .evt(evt)
    );

    wdw_rdmux #(.CNT_W(CNT_W)) u_rd (
        .addr(addr), .load_q(load_q), .count_q(count_q), .win_q(win_q),
        .ctrl_q(ctrl_q), .locked_q(locked_q), .flag_q(flag_q), .rdata(rdata)
    );

    assign irq = flag_q;
endmodule

// File: rtl/wdw_chk.sv
module wdw_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             tick,
    input logic             wr_en,
    input logic [2:0]       addr,
    input logic [CNT_W-1:0] wdata,
    input logic             rst_req,
    input logic             irq,
    input logic [CNT_W-1:0] count,
    input logic [CNT_W-1:0] load,
    input logic [3:0]       ctrl,
    input logic             locked
);
    logic svc;
    assign svc = wr_en && (addr == 3'd1);

    assert_pulse_R3: assert property (@(posedge clk) disable iff (rst)
        rst_req |=> !rst_req);

    assert_stopped_R3: assert property (@(posedge clk) disable iff (rst)
        rst_req |-> !ctrl[0]);

    assert_step_R2: assert property (@(posedge clk) disable iff (rst)
        (ctrl[0] && tick && !svc && count != '0) |=> count == $past(count) - 1'b1);

    assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (!ctrl[0] && !svc) |=> $stable(count));

    assert_lock_R8: assert property (@(posedge clk) disable iff (rst)
        (locked && wr_en && addr == 3'd0) |=> $stable(load));

    assert_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        (irq && !(wr_en && addr == 3'd5 && wdata[0])) |=> irq);
endmodule

bind wdw_win_top wdw_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rst_req(rst_req), .irq(irq), .count(count_q),
    .load(load_q), .ctrl(ctrl_q), .locked(locked_q)
);

// File: tb/sim_wdw_win_top.sv
module sim_wdw_win_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        rst_req, irq;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    wdw_win_top u0 (
        .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .rst_req(rst_req), .irq(irq)
    );

    // {write, addr, data, expected read}
    localparam int NV = 17;
    localparam logic [35:0] TBL [NV] = '{
        {1'b1, 3'd3, 16'h0000, 16'h0000},
        {1'b0, 3'd3, 16'h0000, 16'h0001},
        {1'b1, 3'd0, 16'h0007, 16'h0000},
        {1'b0, 3'd0, 16'h0000, 16'hFFFF},
        {1'b1, 3'd2, 16'h000F, 16'h0000},
        {1'b0, 3'd2, 16'h0000, 16'h0000},
        {1'b1, 3'd4, 16'h0002, 16'h0000},
        {1'b0, 3'd4, 16'h0000, 16'hFFFF},
        {1'b1, 3'd3, 16'h1ACD, 16'h0000},
        {1'b0, 3'd3, 16'h0000, 16'h0001},
        {1'b1, 3'd3, 16'h1ACC, 16'h0000},
        {1'b0, 3'd3, 16'h0000, 16'h0000},
        {1'b1, 3'd0, 16'h0007, 16'h0000},
        {1'b0, 3'd0, 16'h0000, 16'h0007},
        {1'b1, 3'd4, 16'h0002, 16'h0000},
        {1'b0, 3'd4, 16'h0000, 16'h0002},
        {1'b0, 3'd1, 16'h0000, 16'hFFFF}
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        wr_en = 1'b0; addr = a;
        #1 d = rdata;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tick = 1'b1;
            @(negedge clk);
            tick = 1'b0;
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        logic [15:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd(3'd0, v); chk("R1 load", v, 16'hFFFF);
        rd(3'd1, v); chk("R1 count", v, 16'hFFFF);
        rd(3'd2, v); chk("R1 ctrl", v, 16'h0000);
        rd(3'd3, v); chk("R1 lock", v, 16'h0000);
        rd(3'd4, v); chk("R1 win", v, 16'hFFFF);
        chk("R1 rst_req", {15'd0, rst_req}, 16'd0);
        chk("R1 irq", {15'd0, irq}, 16'd0);

        // R8 lock and register table
        for (int i = 0; i < NV; i++) begin
            if (TBL[i][35]) wr(TBL[i][34:32], TBL[i][31:16]);
            else begin
                rd(TBL[i][34:32], v);
                chk("R8 table", v, TBL[i][15:0]);
            end
        end

        // R4 service reload, data ignored
        wr(3'd0, 16'd3);
        wr(3'd1, 16'hDEAD);
        rd(3'd1, v); chk("R4 reload", v, 16'd3);

        // R2 no movement without tick
        wr(3'd2, 16'h0009);
        repeat (3) @(negedge clk);
        rd(3'd1, v); chk("R2 hold", v, 16'd3);
        ticks(3);
        rd(3'd1, v); chk("R2 step", v, 16'd0);
        chk("R3 no early req", {15'd0, rst_req}, 16'd0);

        // R3 timeout
        ticks(1);
        chk("R3 req", {15'd0, rst_req}, 16'd1);
        rd(3'd1, v); chk("R3 reload", v, 16'd3);
        rd(3'd2, v); chk("R3 stop", v, 16'h0008);
        @(negedge clk);
        chk("R3 pulse", {15'd0, rst_req}, 16'd0);

        // R7 stopped service in windowed mode
        wr(3'd0, 16'd10);
        wr(3'd4, 16'd4);
        wr(3'd2, 16'h000A);
        wr(3'd1, 16'h0000);
        chk("R7 no req", {15'd0, rst_req}, 16'd0);
        rd(3'd1, v); chk("R7 reload", v, 16'd10);

        // R5 early service
        wr(3'd2, 16'h000B);
        wr(3'd1, 16'h0000);
        chk("R5 req", {15'd0, rst_req}, 16'd1);
        rd(3'd2, v); chk("R5 stop", v, 16'h000A);

        // R6 service at threshold
        wr(3'd2, 16'h000B);
        ticks(6);
        rd(3'd1, v); chk("R6 count", v, 16'd4);
        wr(3'd1, 16'h0000);
        chk("R6 no req", {15'd0, rst_req}, 16'd0);
        rd(3'd1, v); chk("R6 reload", v, 16'd10);
        rd(3'd2, v); chk("R6 running", v, 16'h000B);

        // R9 interrupt flag
        wr(3'd2, 16'h0005);
        ticks(10);
        chk("R9 not yet", {15'd0, irq}, 16'd0);
        ticks(1);
        chk("R9 irq", {15'd0, irq}, 16'd1);
        chk("R9 no req", {15'd0, rst_req}, 16'd0);
        wr(3'd5, 16'h0000);
        rd(3'd5, v); chk("R9 sticky", v, 16'd1);
        wr(3'd5, 16'h0001);
        chk("R9 cleared", {15'd0, irq}, 16'd0);

        // R10 event and control write in the same cycle
        wr(3'd0, 16'd0);
        wr(3'd1, 16'h0000);
        wr(3'd2, 16'h0001);
        @(negedge clk);
        tick = 1'b1; wr_en = 1'b1; addr = 3'd2; wdata = 16'h0001;
        @(negedge clk);
        tick = 1'b0; wr_en = 1'b0;
        rd(3'd2, v); chk("R10 run cleared", v, 16'h0000);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule